// File: doc/BRIEF.md
# Serial Flash Command Engine

This block lets software issue any serial flash command through a handful of memory-mapped words. One settings word holds the opcode, the number of address bytes, the data direction, the number of data bytes and the bus width. Further words hold the target address and up to four bytes of outgoing data. Writing the go bit starts the command. The engine then lowers chip select and shifts out the opcode on one line. It follows with the address and with the data phase, which either writes data to the flash or reads it back. When the command is done it raises chip select and clears its busy bit.

No command is hard-wired. Erase, program, read, ID and status commands all take the same path. Software describes each one through the settings word. Timing is single-transfer-rate only: one bit slot per serial clock on each active line. The serial clock idles low. Outgoing bits change after a falling edge, and incoming bits are sampled on the rising edge.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, every line output enable is 0, the busy bit reads 0 and the read-data word reads 0.
- R2: The register words are: 0 settings, 1 go/busy, 2 address, 3 write data, 4 read data. Words 0, 2 and 3 read back what was written. In the settings word:
  - bits [7:0] are the opcode;
  - bits [10:8] are the address byte count;
  - bit 11 is the direction (0 write, 1 read);
  - bits [15:12] are the data byte count;
  - bits [17:16] are the bus width (0 single, 1 dual, 2 or 3 quad).
- R3: Writing word 1 with bit 0 set while idle lowers chip select on that clock edge. Bit 0 of word 1 then reads 1 until one serial clock period after chip select has risen again.
- R4: The opcode always goes out on io[0] alone (output enable 0001), most significant bit first, over 8 serial clocks. The serial clock is only high while chip select is low.
- R5: The address phase sends the configured number of bytes, most significant byte first. With 3 bytes, address bits [23:0] are sent. With a count of 0, the address phase is skipped.
- R6: The address and data phases carry 1, 2 or 4 bits per clock:
  - single width uses io[0] (output enable 0001) and reads on io[1];
  - dual width uses io[1:0] (output enable 0011);
  - quad width uses io[3:0] (output enable 1111);
  - the higher-order bit is on the higher-numbered line.
- R7: Write data is taken from word 3 lowest byte first, each byte sent most significant bit first.
- R8: During a read data phase all output enables are 0. Received bytes are packed into word 4 with the first byte in bits [7:0]. Bytes not received read as 0.
- R9: With a data byte count of 0 there is no data phase. Chip select rises after the last address bit, or after the opcode when the address count is also 0.
- R10: A go write while busy is ignored. Rewriting the settings word while busy does not alter the command in progress.
- R11: Chip select stays high for at least one serial clock period (2·HALF_DIV clock cycles) between two commands.
- R12: Address counts above 4 and data counts above 4 are treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 3 | Register word index |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for csr_addr |
| flash_sclk | output | 1 | Serial clock to the flash |
| flash_cs_n | output | 1 | Active-low chip select |
| flash_io_out | output | 4 | Data line outputs |
| flash_io_oe | output | 4 | Per-line output enables |
| flash_io_in | input | 4 | Data line inputs |

## Verification
The bench builds the engine with HALF_DIV set to 3. This odd ratio makes each serial clock half span three system clocks, so the divider reload and the phase transitions are tested away from their simplest case. A flash model in the bench records every rising-edge bit slot and drives read data from a prepared stream. This lets single, dual and quad framing, 0-, 3- and 4-byte addresses, clamped counts and the chip-select gap all be checked against values derived only from the requirements.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int WORD_W    = 32;
  localparam int IO_W      = 4;
  localparam int REG_AW    = 3;
  localparam int MAX_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_OPC, ST_ADR, ST_DAT, ST_HOLD, ST_GAP
  } phase_e;

  localparam logic [REG_AW-1:0] REG_CFG  = 3'd0;
  localparam logic [REG_AW-1:0] REG_GO   = 3'd1;
  localparam logic [REG_AW-1:0] REG_ADDR = 3'd2;
  localparam logic [REG_AW-1:0] REG_TXD  = 3'd3;
  localparam logic [REG_AW-1:0] REG_RXD  = 3'd4;

  typedef struct packed {
    logic [1:0] lanes_lg;
    logic       rd;
    logic [2:0] dlen;
    logic [2:0] alen;
  } cmd_s;

  // Upper settings bits [17:8] -> clamped command shape
  function automatic cmd_s decode_cfg(input logic [9:0] hi);
    cmd_s c;
    c.alen     = (hi[2:0] > 3'd4) ? 3'd4 : hi[2:0];
    c.rd       = hi[3];
    c.dlen     = (hi[7:4] > 4'd4) ? 3'd4 : hi[6:4];
    c.lanes_lg = (hi[9:8] == 2'd0) ? 2'd0 : (hi[9:8] == 2'd1) ? 2'd1 : 2'd2;
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] bswap(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/fcmd_regs.sv
module fcmd_regs
  import fcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] csr_addr,
  input  logic              csr_wr,
  input  logic [WORD_W-1:0] csr_wdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [WORD_W-1:0] rd_word,
  output logic [17:0]       cfg_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] txd_q,
  output logic              start,
  output logic [WORD_W-1:0] csr_rdata
);
  logic [WORD_W-1:0] rxd_q;
  logic cfg_en, addr_en, txd_en;

  assign cfg_en  = csr_wr && (csr_addr == REG_CFG);
  assign addr_en = csr_wr && (csr_addr == REG_ADDR);
  assign txd_en  = csr_wr && (csr_addr == REG_TXD);
  assign start   = csr_wr && (csr_addr == REG_GO) && csr_wdata[0] && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
    end else begin
      if (cfg_en)  cfg_q  <= csr_wdata[17:0];
      if (addr_en) addr_q <= csr_wdata;
      if (txd_en)  txd_q  <= csr_wdata;
      if (rd_done) rxd_q  <= rd_word;
    end
  end

  always_comb begin
    case (csr_addr)
      REG_CFG:  csr_rdata = {14'd0, cfg_q};
      REG_GO:   csr_rdata = {31'd0, busy};
      REG_ADDR: csr_rdata = addr_q;
      REG_TXD:  csr_rdata = txd_q;
      REG_RXD:  csr_rdata = rxd_q;
      default:  csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fcmd_tick.sv
module fcmd_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    if (!run || cnt_q == '0) cnt_d = RELOAD;
    else                     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode_i,
  input  cmd_s              cmd_i,
  input  logic [WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0] txd_i,
  input  logic              tick,
  input  logic [IO_W-1:0]   io_in,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic [IO_W-1:0]   io_out,
  output logic [IO_W-1:0]   io_oe,
  output logic              rd_done,
  output logic [WORD_W-1:0] rd_word
);
  phase_e            state_q, state_d;
  logic              sclk_q, sclk_d, cs_n_q, cs_n_d, gap_q, gap_d;
  logic [WORD_W-1:0] sr_q, sr_d, rx_q, rx_d;
  logic [5:0]        units_q, units_d;
  cmd_s              cmd_q;
  logic [WORD_W-1:0] addr_q, txd_q;
  logic              snap_en;
  logic [1:0]        cur_lg;

  assign busy    = (state_q != ST_IDLE);
  assign cs_n    = cs_n_q;
  assign sclk    = sclk_q;
  assign snap_en = (state_q == ST_IDLE) && start;
  assign cur_lg  = (state_q == ST_ADR || state_q == ST_DAT) ? cmd_q.lanes_lg : 2'd0;

  // next-state logic
  always_comb begin
    state_d = state_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    gap_d   = gap_q;
    sr_d    = sr_q;
    rx_d    = rx_q;
    units_d = units_q;
    rd_done = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SETUP;
        cs_n_d  = 1'b0;
        sr_d    = {opcode_i, 24'h0};
        units_d = 6'd8;
      end
      ST_SETUP: if (tick) state_d = ST_OPC;
      ST_OPC, ST_ADR, ST_DAT: if (tick) begin
        if (!sclk_q) begin
          sclk_d = 1'b1;
          if (state_q == ST_DAT && cmd_q.rd) begin
            case (cmd_q.lanes_lg)
              2'd0:    rx_d = {rx_q[30:0], io_in[1]};
              2'd1:    rx_d = {rx_q[29:0], io_in[1:0]};
              default: rx_d = {rx_q[27:0], io_in};
            endcase
          end
        end else begin
          sclk_d  = 1'b0;
          sr_d    = sr_q << (6'd1 << cur_lg);
          units_d = units_q - 6'd1;
          if (units_q == 6'd1) begin
            if (state_q == ST_OPC && cmd_q.alen != 3'd0) begin
              state_d = ST_ADR;
              sr_d    = addr_q << (6'd32 - {cmd_q.alen, 3'b000});
              units_d = {cmd_q.alen, 3'b000} >> cmd_q.lanes_lg;
            end else if (state_q != ST_DAT && cmd_q.dlen != 3'd0) begin
              state_d = ST_DAT;
              sr_d    = cmd_q.rd ? '0 : bswap(txd_q);
              rx_d    = '0;
              units_d = {cmd_q.dlen, 3'b000} >> cmd_q.lanes_lg;
            end else begin
              state_d = ST_HOLD;
              rd_done = (state_q == ST_DAT) && cmd_q.rd;
            end
          end
        end
      end
      ST_HOLD: if (tick) begin
        cs_n_d  = 1'b1;
        gap_d   = 1'b0;
        state_d = ST_GAP;
      end
      ST_GAP: if (tick) begin
        gap_d = 1'b1;
        if (gap_q) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // read packing: first received byte into [7:0]
  always_comb begin
    logic [4:0]        sh;
    logic [WORD_W-1:0] tmp;
    sh      = '0;
    tmp     = '0;
    rd_word = '0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (3'(k) < cmd_q.dlen) begin
        sh  = 5'((int'(cmd_q.dlen) - 1 - k) * 8);
        tmp = rx_q >> sh;
        rd_word[k*8 +: 8] = tmp[7:0];
      end
    end
  end

  // line drivers
  always_comb begin
    io_out = '0;
    io_oe  = '0;
    if (state_q == ST_SETUP || state_q == ST_OPC) begin
      io_out[0] = sr_q[31];
      io_oe     = 4'b0001;
    end else if (state_q == ST_ADR || (state_q == ST_DAT && !cmd_q.rd)) begin
      case (cmd_q.lanes_lg)
        2'd0: begin io_out[0]   = sr_q[31];    io_oe = 4'b0001; end
        2'd1: begin io_out[1:0] = sr_q[31:30]; io_oe = 4'b0011; end
        default: begin io_out   = sr_q[31:28]; io_oe = 4'b1111; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      gap_q   <= 1'b0;
      sr_q    <= '0;
      rx_q    <= '0;
      units_q <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      gap_q   <= gap_d;
      sr_q    <= sr_d;
      rx_q    <= rx_d;
      units_q <= units_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      txd_q  <= '0;
    end else if (snap_en) begin
      cmd_q  <= cmd_i;
      addr_q <= addr_i;
      txd_q  <= txd_i;
    end
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fcmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  csr_addr,
  input  logic        csr_wr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        flash_sclk,
  output logic        flash_cs_n,
  output logic [3:0]  flash_io_out,
  output logic [3:0]  flash_io_oe,
  input  logic [3:0]  flash_io_in
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [17:0]       cfg_w;
  logic [WORD_W-1:0] addr_w, txd_w, rd_word_w;
  logic              start_w, busy_w, tick_w, rd_done_w;
  cmd_s              cmd_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign cmd_w = decode_cfg(cfg_w[17:8]);

  fcmd_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .busy(busy_w), .rd_done(rd_done_w), .rd_word(rd_word_w),
    .cfg_q(cfg_w), .addr_q(addr_w), .txd_q(txd_w), .start(start_w), .csr_rdata(csr_rdata)
  );

  fcmd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n_s), .run(busy_w), .tick(tick_w)
  );

  fcmd_seq u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(start_w), .opcode_i(cfg_w[7:0]), .cmd_i(cmd_w),
    .addr_i(addr_w), .txd_i(txd_w), .tick(tick_w), .io_in(flash_io_in),
    .busy(busy_w), .cs_n(flash_cs_n), .sclk(flash_sclk), .io_out(flash_io_out),
    .io_oe(flash_io_oe), .rd_done(rd_done_w), .rd_word(rd_word_w)
  );
endmodule

// File: rtl/fcmd_engine_chk.sv
module fcmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       busy
);
  // R4
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R6
  oe_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111));
  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $fell(cs_n));
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(busy));
  // R11
  gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy);
endmodule

bind flash_cmd_engine fcmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .cs_n(flash_cs_n), .sclk(flash_sclk),
  .io_oe(flash_io_oe), .busy(busy_w)
);

// File: tb/tb_flash_cmd_engine.sv
module tb_flash_cmd_engine;
  localparam int TCLK = 10;
  localparam int HALF = 3;

  logic        clk, rst_n, csr_wr;
  logic [2:0]  csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        flash_sclk, flash_cs_n;
  logic [3:0]  flash_io_out, flash_io_oe, flash_io_in;

  int vec = 0, bad = 0;
  int n = 0, frames = 0, pre = 0, hi_cnt = 0, last_gap = 0;
  logic [3:0] rec_out [0:63];
  logic [3:0] rec_oe  [0:63];
  logic [3:0] rd_units [0:63];

  flash_cmd_engine #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .flash_sclk(flash_sclk),
    .flash_cs_n(flash_cs_n), .flash_io_out(flash_io_out), .flash_io_oe(flash_io_oe),
    .flash_io_in(flash_io_in)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  // flash model: record bit slots on rising sclk, restart on chip-select fall
  always @(posedge flash_sclk or negedge flash_cs_n) begin
    if (flash_sclk) begin
      if (n < 64) begin rec_out[n] = flash_io_out; rec_oe[n] = flash_io_oe; end
      n = n + 1;
    end else begin
      n = 0;
      frames = frames + 1;
    end
  end

  always @(negedge clk) begin
    if (flash_cs_n) hi_cnt = hi_cnt + 1;
    else begin
      if (hi_cnt != 0) last_gap = hi_cnt;
      hi_cnt = 0;
    end
  end

  assign flash_io_in = (n >= pre && (n - pre) < 64) ? rd_units[n - pre] : 4'h0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd1, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic [7:0] get_byte(input int s, input int lg);
    logic [7:0] b = 8'h0;
    for (int i = 0; i < (8 >> lg); i++) begin
      case (lg)
        0: b = {b[6:0], rec_out[s+i][0]};
        1: b = {b[5:0], rec_out[s+i][1:0]};
        default: b = {b[3:0], rec_out[s+i]};
      endcase
    end
    return b;
  endfunction

  function automatic logic oe_all(input int s, input int cnt, input logic [3:0] v);
    logic ok = 1'b1;
    for (int i = s; i < s + cnt; i++) if (rec_oe[i] !== v) ok = 1'b0;
    return ok;
  endfunction

  task automatic load_stream(input logic [31:0] w, input int nb, input int lg);
    int idx = 0;
    for (int k = 0; k < nb; k++) begin
      logic [7:0] b = w[k*8 +: 8];
      for (int u = 0; u < (8 >> lg); u++) begin
        case (lg)
          0: rd_units[idx] = {2'b00, b[7 - u], 1'b0};
          1: rd_units[idx] = {2'b00, b[7 - 2*u -: 2]};
          default: rd_units[idx] = b[7 - 4*u -: 4];
        endcase
        idx++;
      end
    end
  endtask

  task automatic run_cmd(input logic [31:0] cfg, input logic [31:0] a, input logic [31:0] d);
    wr(3'd0, cfg);
    wr(3'd2, a);
    wr(3'd3, d);
    wr(3'd1, 32'h1);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 cs_n", {31'd0, flash_cs_n}, 32'd1);
    chk("R1 sclk", {31'd0, flash_sclk}, 32'd0);
    chk("R1 oe", {28'd0, flash_io_oe}, 32'd0);
    rd(3'd1, v); chk("R1 busy", v, 32'd0);
    rd(3'd4, v); chk("R1 rdata", v, 32'd0);
  endtask

  task automatic t_erase();
    logic [31:0] v;
    run_cmd(32'h0000_04D8, 32'h0000_1000, 32'h0);
    chk("R9 slots", n, 40);
    chk("R4 opcode", get_byte(0, 0), 8'hD8);
    chk("R4 opcode oe", oe_all(0, 8, 4'b0001), 1);
    chk("R5 addr4", {get_byte(8,0), get_byte(16,0), get_byte(24,0), get_byte(32,0)}, 32'h0000_1000);
    rd(3'd0, v); chk("R2 cfg readback", v, 32'h0000_04D8);
    rd(3'd2, v); chk("R2 addr readback", v, 32'h0000_1000);
  endtask

  task automatic t_addr3();
    run_cmd(32'h0000_0320, 32'hAB12_3456, 32'h0);
    chk("R5 slots3", n, 32);
    chk("R5 addr3", {8'h0, get_byte(8,0), get_byte(16,0), get_byte(24,0)}, 32'h0012_3456);
  endtask

  task automatic t_write_dual();
    logic [31:0] v;
    run_cmd(32'h0001_23A2, 32'h00C0_FFEE, 32'h1234_BEEF);
    chk("R6 dual slots", n, 28);
    chk("R4 opcode dual", get_byte(0, 0), 8'hA2);
    chk("R6 dual addr", {8'h0, get_byte(8,1), get_byte(12,1), get_byte(16,1)}, 32'h00C0_FFEE);
    chk("R6 dual oe", oe_all(8, 20, 4'b0011), 1);
    chk("R7 wdata order", {get_byte(20,1), get_byte(24,1)}, 16'hEFBE);
    rd(3'd3, v); chk("R2 wdata readback", v, 32'h1234_BEEF);
  endtask

  task automatic t_read_quad();
    logic [31:0] v;
    pre = 14;
    load_stream(32'h4433_2211, 4, 2);
    run_cmd(32'h0002_4BEB, 32'h0000_0100, 32'h0);
    chk("R8 quad slots", n, 22);
    chk("R8 read oe off", oe_all(14, 8, 4'b0000), 1);
    chk("R6 quad addr oe", oe_all(8, 6, 4'b1111), 1);
    rd(3'd4, v); chk("R8 quad rdata", v, 32'h4433_2211);
  endtask

  task automatic t_read_single();
    logic [31:0] v;
    pre = 8;
    load_stream(32'h007E_3CA5, 3, 0);
    run_cmd(32'h0000_389F, 32'h0, 32'h0);
    chk("R9 no addr slots", n, 32);
    rd(3'd4, v); chk("R8 R6 single rdata", v, 32'h007E_3CA5);
  endtask

  task automatic t_clamp();
    run_cmd(32'h0002_9702, 32'hDEAD_BEEF, 32'h0403_0201);
    chk("R12 slots", n, 24);
    chk("R12 addr", {get_byte(8,2), get_byte(10,2), get_byte(12,2), get_byte(14,2)}, 32'hDEAD_BEEF);
    chk("R12 wdata", {get_byte(16,2), get_byte(18,2), get_byte(20,2), get_byte(22,2)}, 32'h0102_0304);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int f0;
    f0 = frames;
    wr(3'd0, 32'h0000_04D8);
    wr(3'd2, 32'h0000_2000);
    wr(3'd1, 32'h1);
    rd(3'd1, v); chk("R3 busy set", v, 32'd1);
    wr(3'd0, 32'h0000_00AB);
    wr(3'd1, 32'h1);
    wait_idle();
    repeat (60) @(negedge clk);
    chk("R10 one frame", frames - f0, 1);
    chk("R10 opcode kept", get_byte(0, 0), 8'hD8);
    chk("R10 slots kept", n, 40);
  endtask

  task automatic t_gap();
    run_cmd(32'h0000_0006, 32'h0, 32'h0);
    wr(3'd1, 32'h1);
    wait_idle();
    chk("R11 gap", (last_gap >= 2*HALF) ? 1 : 0, 1);
    chk("R9 opcode only", n, 8);
  endtask

  initial begin
    #(TCLK * 150000);
    bad++;
    $display("FAIL watchdog R1-all actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; csr_wr = 1'b0; csr_addr = 3'd0; csr_wdata = 32'h0;
    for (int i = 0; i < 64; i++) rd_units[i] = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_erase();
    t_addr3();
    t_write_dual();
    t_read_quad();
    t_read_single();
    t_clamp();
    t_busy_ignore();
    t_gap();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule